// File: doc/BRIEF.md
# Reset Control Port Register

This block is a one-byte register sitting in I/O space that lets software ask for a platform reset. A byte written to the register's port with the trigger bit set raises a single-cycle reset request towards the downstream reset sequencer, and the register contents stay as they were. A byte written with the trigger bit clear does not raise a request. Instead it records the reset type that later requests should use. Two type bits are stored: bit 3 selects a full reset and bit 1 selects a system reset. Every other written bit is discarded.

Reads at the same port return the stored byte, with every bit outside the two type bits reading as zero. The two stored type bits are also driven out at all times, so the sequencer can pick the reset flavour in the cycle the request pulse arrives. Device reset clears the register. Port address, bit positions and read latency are parameters. The default places the register at port 0xCF9 with a combinational read path.

Top module: `rst_ctrl_port`

## Requirements
- R1: While and after device reset (active-low `rst_n`), the stored byte is 0x00, `rst_req` is low and `rst_full`/`rst_sys` are low.
- R2: A write (`io_wr` high, `io_addr` equal to 0xCF9) whose data has bit 2 clear stores `io_wdata & 8'h0A`. The new value is visible from the next clock edge.
- R3: A write to 0xCF9 whose data has bit 2 set drives `rst_req` high for exactly the cycle after the write edge. The stored byte is left unchanged.
- R4: A read (`io_rd` high, `io_addr` equal to 0xCF9) returns the stored byte on `io_rdata` in the same cycle. Bits 0, 2 and 4 to 7 of that byte are always zero.
- R5: A write to any other address, or any cycle with `io_wr` low, changes neither the stored byte nor `rst_req`.
- R6: `rst_full` always equals stored bit 3, and `rst_sys` always equals stored bit 1, including in the cycle `rst_req` is high.
- R7: `rst_req` is low in every cycle that does not follow a triggering write. Two triggering writes on consecutive cycles keep it high for two cycles.
- R8: `io_rdata` is 0x00 whenever `io_rd` is low or `io_addr` differs from 0xCF9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset, synchronous |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data byte, zero when not selected |
| rst_req | output | 1 | Reset request pulse, one cycle per triggering write |
| rst_full | output | 1 | Stored full-reset selection bit |
| rst_sys | output | 1 | Stored system-reset selection bit |

## Verification
The bench builds the block with its default parameters: a 16-bit port address at 0xCF9, trigger at bit 2, type bits at 3 and 1, and a zero-latency read. With these values the bench can read back a write's effect one cycle after it and watch `rst_req` in the same cycle. It can also compare the stored bits against the side outputs directly. The address neighbours 0xCF8 and 0xCFA are used to check the decode. Written bytes mixing the trigger with type and junk bits show that a trigger never disturbs the stored type.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

   // Build a mask from the two retained type-bit positions.
   function automatic logic [7:0] keep_mask8(input int full_pos, input int sys_pos);
      logic [7:0] m;
      m = '0;
      m[full_pos] = 1'b1;
      m[sys_pos]  = 1'b1;
      return m;
   endfunction

   localparam int          DEF_ADDR_W   = 16;
   localparam int          DEF_DATA_W   = 8;
   localparam logic [15:0] DEF_PORT     = 16'hCF9;
   localparam int          DEF_TRIG_POS = 2;
   localparam int          DEF_FULL_POS = 3;
   localparam int          DEF_SYS_POS  = 1;

endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic              trig_bit,
   output logic              rd_hit,
   output logic              fire,
   output logic              store_en
);

   logic sel;

   always_comb begin
      sel      = (io_addr == PORT_ADDR);
      rd_hit   = sel && io_rd;
      fire     = sel && io_wr && trig_bit;
      store_en = sel && io_wr && !trig_bit;
   end

endmodule

// File: rtl/rstctl_store.sv
module rstctl_store #(
   parameter int              DATA_W = 8,
   parameter logic [DATA_W-1:0] KEEP = 8'h0A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (store_en) q <= wdata & KEEP;
   end

   // R4
   only_kept_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~KEEP) == '0);

   // R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !store_en |=> q == $past(q));

endmodule

// File: rtl/rstctl_pulse.sv
module rstctl_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic req
);

   always_ff @(posedge clk) begin
      if (!rst_n) req <= 1'b0;
      else        req <= fire;
   end

   // R3
   pulse_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> req);

   // R7
   quiet_without_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !req);

endmodule

// File: rtl/rst_ctrl_port.sv
module rst_ctrl_port
   import rstctl_pkg::*;
#(
   parameter int                ADDR_W    = DEF_ADDR_W,
   parameter int                DATA_W    = DEF_DATA_W,
   parameter logic [ADDR_W-1:0] PORT_ADDR = DEF_PORT,
   parameter int                TRIG_POS  = DEF_TRIG_POS,
   parameter int                FULL_POS  = DEF_FULL_POS,
   parameter int                SYS_POS   = DEF_SYS_POS,
   parameter int                READ_LAT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [DATA_W-1:0] io_rdata,
   output logic              rst_req,
   output logic              rst_full,
   output logic              rst_sys
);

   localparam logic [DATA_W-1:0] KEEP = DATA_W'(keep_mask8(FULL_POS, SYS_POS));

   generate
      if (DATA_W != 8)
         $error("rst_ctrl_port: DATA_W must be 8");
      if (TRIG_POS >= DATA_W || FULL_POS >= DATA_W || SYS_POS >= DATA_W)
         $error("rst_ctrl_port: bit position out of range");
      if (TRIG_POS == FULL_POS || TRIG_POS == SYS_POS || FULL_POS == SYS_POS)
         $error("rst_ctrl_port: bit positions must differ");
      if (READ_LAT != 0 && READ_LAT != 1)
         $error("rst_ctrl_port: READ_LAT must be 0 or 1");
   endgenerate

   logic              rd_hit;
   logic              fire;
   logic              store_en;
   logic [DATA_W-1:0] stored;

   rstctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
      .io_addr  (io_addr),
      .io_wr    (io_wr),
      .io_rd    (io_rd),
      .trig_bit (io_wdata[TRIG_POS]),
      .rd_hit   (rd_hit),
      .fire     (fire),
      .store_en (store_en)
   );

   rstctl_store #(.DATA_W(DATA_W), .KEEP(KEEP)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .store_en (store_en),
      .wdata    (io_wdata),
      .q        (stored)
   );

   rstctl_pulse u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .req   (rst_req)
   );

   assign rst_full = stored[FULL_POS];
   assign rst_sys  = stored[SYS_POS];

   generate
      if (READ_LAT == 0) begin : g_rd_comb
         assign io_rdata = rd_hit ? stored : '0;
      end else begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_hit ? stored : '0;
         end
         assign io_rdata = rd_q;
      end
   endgenerate

   // R2
   type_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_ADDR && !io_wdata[TRIG_POS])
      |=> (rst_full == $past(io_wdata[FULL_POS]) && rst_sys == $past(io_wdata[SYS_POS])));

   // R3
   trig_keeps_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_ADDR && io_wdata[TRIG_POS])
      |=> (rst_full == $past(rst_full) && rst_sys == $past(rst_sys)));

   // R8
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (READ_LAT == 0 && !(io_rd && io_addr == PORT_ADDR)) |-> io_rdata == '0);

endmodule

// File: tb/tb_rst_ctrl_port.sv
module tb_rst_ctrl_port;

   typedef struct packed {
      logic [15:0] addr;
      logic [7:0]  wdata;
      logic        wr;
      logic [7:0]  exp_q;
      logic        exp_req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{16'hCF9, 8'hFF, 1'b1, 8'h00, 1'b1},
      '{16'hCF9, 8'h0A, 1'b1, 8'h0A, 1'b0},
      '{16'hCF9, 8'hF5, 1'b1, 8'h0A, 1'b1},
      '{16'hCF9, 8'hF1, 1'b1, 8'h00, 1'b0},
      '{16'hCF9, 8'hFA, 1'b1, 8'h0A, 1'b0},
      '{16'hCF8, 8'h00, 1'b1, 8'h0A, 1'b0},
      '{16'hCF9, 8'h00, 1'b0, 8'h0A, 1'b0},
      '{16'hCFA, 8'h04, 1'b1, 8'h0A, 1'b0},
      '{16'hCF9, 8'h08, 1'b1, 8'h08, 1'b0},
      '{16'hCF9, 8'h0C, 1'b1, 8'h08, 1'b1},
      '{16'hCF9, 8'h02, 1'b1, 8'h02, 1'b0},
      '{16'hCF9, 8'h06, 1'b1, 8'h02, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        rst_req;
   logic        rst_full;
   logic        rst_sys;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   rst_ctrl_port dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .rst_req(rst_req),
      .rst_full(rst_full), .rst_sys(rst_sys)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic idle();
      io_wr = 1'b0; io_rd = 1'b0; io_addr = 16'h0000; io_wdata = 8'h00;
   endtask

   // Read back the stored byte and side outputs in the current (post-edge) cycle.
   task automatic readback(input string tag, input logic [7:0] exp_q);
      io_wr = 1'b0; io_rd = 1'b1; io_addr = 16'hCF9;
      #1;
      chk({tag, " R4 rdata"}, io_rdata, exp_q);
      chk({tag, " R6 full"}, {7'd0, rst_full}, {7'd0, exp_q[3]});
      chk({tag, " R6 sys"}, {7'd0, rst_sys}, {7'd0, exp_q[1]});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state while in reset
      io_rd = 1'b1; io_addr = 16'hCF9;
      #1;
      chk("R1 rdata in reset", io_rdata, 8'h00);
      chk("R1 req in reset", {7'd0, rst_req}, 8'h00);
      chk("R1 full/sys in reset", {6'd0, rst_full, rst_sys}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      idle();

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         io_addr = VECS[i].addr; io_wdata = VECS[i].wdata; io_wr = VECS[i].wr; io_rd = 1'b0;
         @(negedge clk);
         // R3 / R5 / R7: pulse in the cycle after the write
         chk($sformatf("R3 R5 R7 vec%0d req", i), {7'd0, rst_req}, {7'd0, VECS[i].exp_req});
         // R2 / R3 / R5: stored value
         readback($sformatf("R2 R3 R5 vec%0d", i), VECS[i].exp_q);
         @(negedge clk);
         idle();
         #1;
         chk($sformatf("R7 vec%0d req drops", i), {7'd0, rst_req}, 8'h00);
      end

      // R8: read at a neighbouring address and with no strobe
      @(negedge clk);
      io_rd = 1'b1; io_addr = 16'hCF8;
      #1 chk("R8 read wrong address", io_rdata, 8'h00);
      io_rd = 1'b0; io_addr = 16'hCF9;
      #1 chk("R8 read without strobe", io_rdata, 8'h00);

      // R7: back-to-back triggers keep the request high two cycles
      @(negedge clk);
      io_addr = 16'hCF9; io_wdata = 8'h04; io_wr = 1'b1; io_rd = 1'b0;
      @(negedge clk);
      io_wdata = 8'hFE;
      #1 chk("R7 b2b first", {7'd0, rst_req}, 8'h01);
      @(negedge clk);
      idle();
      #1 chk("R7 b2b second", {7'd0, rst_req}, 8'h01);
      @(negedge clk);
      #1 chk("R7 b2b end", {7'd0, rst_req}, 8'h00);
      readback("R3 b2b keeps type", 8'h02);

      // R1: reset in mid-operation clears the stored type
      @(negedge clk);
      io_addr = 16'hCF9; io_wdata = 8'h0A; io_wr = 1'b1;
      @(negedge clk);
      idle();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      readback("R1 after reset", 8'h00);
      chk("R1 req after reset", {7'd0, rst_req}, 8'h00);

      @(negedge clk);
      idle();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule